// File: doc/BRIEF.md
# Hashed page table initialization sequencer

This block prepares a hashed page table before address translation is switched on. Given a table base address and a table-size mask, it first checks the base against the mask. A misaligned base raises an error flag and nothing else happens. For a good base, it loads a table-descriptor register with the origin and the mask. It then zeroes every table entry through a word-wide memory write port.

After the last zero word is accepted, the block sends a run of TLB-invalidate requests on a separate port. Each request targets the next page in turn. When the last invalidate is accepted, a one-cycle done pulse is raised.

Both request ports use a valid/ready handshake. A slow memory or a slow TLB stalls the sequence without losing any request. The block is started once by a pulse. A start pulse that arrives while a sequence is running has no effect.

Top module: `ptinit_seq`

## Requirements
- R1: After synchronous reset, busy, done, err, mem_valid and inv_valid are 0, and the descriptor output is 0.
- R2: A start pulse is rejected when base_addr bitwise ANDed with the zero-extended size_mask is non-zero. A rejected start sets err in the next cycle, issues no memory write and no invalidate, gives no done pulse, and leaves the descriptor unchanged.
- R3: An accepted start loads the descriptor with base_addr bits 31..16, followed by 16 zero bits, ORed with the zero-extended size_mask.
- R4: The clear phase issues exactly 2*ENTRIES writes, all of data zero. The byte addresses start at base_addr and rise by 4 per write, so entry k has its upper word at base+8k and its lower word at base+8k+4, in that order.
- R5: After the last write is accepted, exactly NUM_INVAL (64) invalidate requests follow. Request i carries address i shifted left by 12. The first request carries address 0.
- R6: A request held with valid high and ready low keeps its valid and its address unchanged until it is accepted. mem_valid and inv_valid are never high together.
- R7: done is high for exactly one cycle: the cycle after the last invalidate is accepted. During that cycle busy is low.
- R8: A start pulse while busy is ignored. The descriptor, the write count, the write addresses and the invalidate count of the running sequence are unaffected. This holds even when the pulse coincides with the acceptance of the final invalidate.
- R9: An accepted start clears an err flag left by an earlier rejected start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| base_addr | input | 32 | Table base byte address |
| size_mask | input | 9 | Table-size mask field |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Alignment error flag |
| desc_q | output | 32 | Table-descriptor register |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data (always zero) |
| inv_valid | output | 1 | TLB-invalidate request valid |
| inv_ready | input | 1 | TLB-invalidate accepted |
| inv_addr | output | 32 | Invalidate address |

## Verification
A fresh start request can land in the very cycle in which the final invalidate is handshaken. That is also the cycle in which the sequencer decides to return to idle. The bench provokes this overlap by raising start exactly when it also raises inv_ready for request 63. It judges the result by four things: a single done pulse, no further memory write, no error, and an unchanged descriptor. A second injection lands a start mid-way through the clear phase under random back-pressure. There the write count and the address stream must match an undisturbed run.

// File: rtl/ptinit_pkg.sv
package ptinit_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CLEAR = 2'd1,
    S_INVAL = 2'd2
  } ptinit_state_t;
endpackage

// File: rtl/ptinit_counter.sv
module ptinit_counter #(
  parameter int LIMIT = 4,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic at_last
);
  logic [W-1:0] value;

  always_ff @(posedge clk) begin
    if (rst || clr)
      value <= '0;
    else if (step)
      value <= value + W'(1);
  end

  assign at_last = (value == W'(LIMIT - 1));
endmodule

// File: rtl/ptinit_origin.sv
module ptinit_origin #(
  parameter int ADDR_W     = 32,
  parameter int ORIGIN_LSB = 16,
  parameter int MASK_W     = 9
) (
  input  logic [ADDR_W-ORIGIN_LSB-1:0] base_hi,
  input  logic [MASK_W-1:0]            base_lo,
  input  logic [MASK_W-1:0]            size_mask,
  output logic                         misaligned,
  output logic [ADDR_W-1:0]            desc
);
  assign misaligned = |(base_lo & size_mask);
  assign desc = {base_hi, {ORIGIN_LSB{1'b0}}} | ADDR_W'(size_mask);
endmodule

// File: rtl/ptinit_seq.sv
module ptinit_seq
  import ptinit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ORIGIN_LSB = 16,
  parameter int MASK_W     = 9,
  parameter int ENTRIES    = 8192,
  parameter int NUM_INVAL  = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [MASK_W-1:0] size_mask,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] desc_q,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [ADDR_W-1:0] inv_addr
);
  localparam int WORDS      = 2 * ENTRIES;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(1) << PAGE_SHIFT;

  ptinit_state_t st;
  logic          bad_base;
  logic [ADDR_W-1:0] desc_next;
  logic          go_ok;
  logic          wr_fire, inv_fire;
  logic          wr_last, inv_last;

  ptinit_origin #(
    .ADDR_W(ADDR_W), .ORIGIN_LSB(ORIGIN_LSB), .MASK_W(MASK_W)
  ) u_origin (
    .base_hi   (base_addr[ADDR_W-1:ORIGIN_LSB]),
    .base_lo   (base_addr[MASK_W-1:0]),
    .size_mask (size_mask),
    .misaligned(bad_base),
    .desc      (desc_next)
  );

  assign go_ok    = (st == S_IDLE) && start && !bad_base;
  assign wr_fire  = (st == S_CLEAR) && mem_valid && mem_ready;
  assign inv_fire = (st == S_INVAL) && inv_valid && inv_ready;

  ptinit_counter #(.LIMIT(WORDS)) u_wcnt (
    .clk(clk), .rst(rst), .clr(go_ok), .step(wr_fire), .at_last(wr_last)
  );

  ptinit_counter #(.LIMIT(NUM_INVAL)) u_icnt (
    .clk(clk), .rst(rst), .clr(go_ok), .step(inv_fire), .at_last(inv_last)
  );

  assign busy      = (st != S_IDLE);
  assign mem_wdata = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      err       <= 1'b0;
      done      <= 1'b0;
      desc_q    <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      inv_valid <= 1'b0;
      inv_addr  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            if (bad_base) begin
              err <= 1'b1;
            end else begin
              err       <= 1'b0;
              desc_q    <= desc_next;
              mem_addr  <= base_addr;
              mem_valid <= 1'b1;
              st        <= S_CLEAR;
            end
          end
        end
        S_CLEAR: begin
          if (wr_fire) begin
            if (wr_last) begin
              mem_valid <= 1'b0;
              inv_valid <= 1'b1;
              inv_addr  <= '0;
              st        <= S_INVAL;
            end else begin
              mem_addr <= mem_addr + ADDR_STEP;
            end
          end
        end
        S_INVAL: begin
          if (inv_fire) begin
            if (inv_last) begin
              inv_valid <= 1'b0;
              done      <= 1'b1;
              st        <= S_IDLE;
            end else begin
              inv_addr <= inv_addr + PAGE_STEP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptinit_seq_chk.sv
module ptinit_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              inv_valid,
  input logic              inv_ready,
  input logic [ADDR_W-1:0] inv_addr
);
  localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] PSTEP = ADDR_W'(1) << PAGE_SHIFT;

  a_r2_err_no_request: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_valid && !inv_valid));

  a_r4_zero_data: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_wdata == '0));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + WSTEP));

  a_r5_first_page: assert property (@(posedge clk) disable iff (rst)
    $rose(inv_valid) |-> (inv_addr == '0));

  a_r5_page_step: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_ready) |=> (!inv_valid || inv_addr == $past(inv_addr) + PSTEP));

  a_r6_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  a_r6_inv_hold: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_addr)));

  a_r6_one_port: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && inv_valid));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind ptinit_seq ptinit_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (.*);

// File: tb/sim_ptinit_seq.sv
module sim_ptinit_seq;
  localparam int ENT = 16;
  localparam int NI  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_t = 1'b0;
  logic        inj_start = 1'b0;
  logic        start;
  logic [31:0] base_addr = '0;
  logic [8:0]  size_mask = '0;
  logic        busy, done, err;
  logic [31:0] desc_q;
  logic        mem_valid, inv_valid;
  logic        mem_ready = 1'b0, inv_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, inv_addr;

  int errors = 0;
  int checks = 0;

  logic        stall_mode = 1'b0;
  logic        inj_mid = 1'b0, inj_end = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_maddr = '0;
  int wcount = 0, icount = 0, done_cnt = 0;
  int addr_err = 0, inv_err = 0, hold_err = 0, overlap_err = 0;
  logic        mprev_stall = 1'b0, iprev_stall = 1'b0;
  logic [31:0] mprev_addr = '0, iprev_addr = '0;

  assign start = start_t | inj_start;

  always #4 clk = ~clk;

  ptinit_seq #(.ENTRIES(ENT), .NUM_INVAL(NI)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .size_mask(size_mask), .busy(busy), .done(done), .err(err),
    .desc_q(desc_q), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .inv_valid(inv_valid),
    .inv_ready(inv_ready), .inv_addr(inv_addr)
  );

  // Memory and TLB models: ready is set here at the falling edge,
  // and a handshake seen here completes on the next rising edge.
  always @(negedge clk) begin
    inj_start = 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
    inv_ready = stall_mode ? (lfsr[3:2] != 2'b00) : 1'b1;
    if (!rst) begin
      if (mprev_stall && !(mem_valid && mem_addr == mprev_addr)) hold_err++;
      if (iprev_stall && !(inv_valid && inv_addr == iprev_addr)) hold_err++;
      mprev_stall = mem_valid && !mem_ready;
      mprev_addr  = mem_addr;
      iprev_stall = inv_valid && !inv_ready;
      iprev_addr  = inv_addr;
      if (mem_valid && inv_valid) overlap_err++;
      if (mem_valid && mem_ready) begin
        if (mem_addr != exp_maddr || mem_wdata != 32'd0) addr_err++;
        exp_maddr = exp_maddr + 32'd4;
        wcount++;
        if (inj_mid && wcount == 5) inj_start = 1'b1;
      end
      if (inv_valid && inv_ready) begin
        if (inv_addr != (32'(icount) << 12)) inv_err++;
        icount++;
        if (inj_end && icount == NI) inj_start = 1'b1;
      end
      if (done) done_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stats(input logic [31:0] base);
    @(posedge clk);
    exp_maddr = base; wcount = 0; icount = 0; done_cnt = 0;
    addr_err = 0; inv_err = 0; hold_err = 0; overlap_err = 0;
  endtask

  task automatic pulse_start(input logic [31:0] base, input logic [8:0] mask);
    @(negedge clk);
    base_addr = base; size_mask = mask; start_t = 1'b1;
    @(negedge clk); #1;
    start_t = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 desc", desc_q, 32'd0);
    chk("R1 req", {30'd0, mem_valid, inv_valid}, 32'd0);
  endtask

  task automatic t_misaligned(input logic [31:0] base, input logic [8:0] mask);
    logic [31:0] old_desc;
    old_desc = desc_q;
    clear_stats(base);
    pulse_start(base, mask);
    chk("R2 err set", {31'd0, err}, 32'd1);
    chk("R2 idle", {31'd0, busy}, 32'd0);
    repeat (6) @(negedge clk);
    #1;
    chk("R2 no writes", 32'(wcount), 32'd0);
    chk("R2 no invalidates", 32'(icount), 32'd0);
    chk("R2 no done", 32'(done_cnt), 32'd0);
    chk("R2 desc kept", desc_q, old_desc);
  endtask

  task automatic t_run(input logic [31:0] base, input logic [8:0] mask,
                       input logic stall, input logic mid, input logic fin,
                       input string tag);
    logic [31:0] exp_desc;
    int n;
    exp_desc = {base[31:16], 16'd0} | {23'd0, mask};
    stall_mode = stall; inj_mid = mid; inj_end = fin;
    clear_stats(base);
    pulse_start(base, mask);
    chk({tag, " R3 desc"}, desc_q, exp_desc);
    chk({tag, " R9 err clear"}, {31'd0, err}, 32'd0);
    base_addr = 32'h0BAD_0000; size_mask = 9'h000;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); #1;
      n++;
    end
    chk({tag, " R7 done seen"}, {31'd0, done}, 32'd1);
    chk({tag, " R7 idle at done"}, {31'd0, busy}, 32'd0);
    chk({tag, " R4 write count"}, 32'(wcount), 32'(2 * ENT));
    chk({tag, " R4 write addr/data"}, 32'(addr_err), 32'd0);
    chk({tag, " R5 inval count"}, 32'(icount), 32'(NI));
    chk({tag, " R5 inval addr"}, 32'(inv_err), 32'd0);
    chk({tag, " R6 hold/overlap"}, 32'(hold_err + overlap_err), 32'd0);
    @(negedge clk); #1;
    chk({tag, " R7 one-cycle done"}, {31'd0, done}, 32'd0);
    repeat (4) @(negedge clk);
    #1;
    chk({tag, " R8 stays idle"}, {30'd0, busy, mem_valid}, 32'd0);
    chk({tag, " R8 desc unchanged"}, desc_q, exp_desc);
    chk({tag, " R8 single done"}, 32'(done_cnt), 32'd1);
    chk({tag, " R8 no extra writes"}, 32'(wcount), 32'(2 * ENT));
    stall_mode = 1'b0; inj_mid = 1'b0; inj_end = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_misaligned(32'h0040_0010, 9'h1F0);
    t_run(32'h0040_0000, 9'h1F0, 1'b0, 1'b0, 1'b0, "aligned");
    t_misaligned(32'h0012_0004, 9'h00F);
    t_run(32'h0020_0100, 9'h003, 1'b1, 1'b0, 1'b0, "stall");
    t_run(32'h7FFF_0000, 9'h000, 1'b1, 1'b1, 1'b0, "mid-start");
    t_run(32'h0003_0000, 9'h0FF, 1'b0, 1'b0, 1'b1, "end-start");
    t_run(32'h0005_0000, 9'h001, 1'b1, 1'b1, 1'b1, "both");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule